// File: doc/BRIEF.md
# Halfword-Select Signed Multiply Unit

This block is a registered signed multiplier for a processor datapath. It takes two 32-bit operands. Select inputs pick the top or bottom 16-bit half of each operand. A mode input chooses what is multiplied and which part of the product is returned. In half-by-half mode, one signed half of each operand is multiplied and the whole 32-bit signed product is returned. In word-by-half mode, the first operand as a full signed word is multiplied by one signed half of the second operand, and the upper 32 bits of the 48-bit product are returned.

Internally, both modes share one signed 32x16 multiplier. In half-by-half mode, the first operand's selected half is sign-extended to 32 bits before it enters the multiplier. The result register loads only on cycles with a valid request, and the valid flag follows the request strobe by one clock. Register access, condition evaluation and instruction decode are handled outside the block.

Top module: `hsmul_unit`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and result_o is 0.
- R2: valid_o equals the value valid_i had at the previous rising clock edge, so it follows the request strobe by exactly one clock.
- R3: A half select of 0 takes operand bits [15:0] and a select of 1 takes bits [31:16]. sel_a_i and sel_b_i act independently in half-by-half mode, giving all four combinations.
- R4: With mode_i = 0 (half-by-half), result_o one clock after a valid request is the 32-bit signed product of the two selected halves, each treated as signed 16-bit. There is no saturation: -32768 x -32768 gives 0x40000000.
- R5: With mode_i = 1 (word-by-half), result_o one clock after a valid request is bits [47:16] of the signed 48-bit product of op_a_i (signed 32-bit) and the half of op_b_i chosen by sel_b_i (signed 16-bit).
- R6: In word-by-half mode the discarded 16 low product bits are truncated, not rounded, so negative products round toward minus infinity (for example 0xFFFFFFFF x 1 gives 0xFFFFFFFF).
- R7: In word-by-half mode, sel_a_i has no effect on result_o.
- R8: In a cycle where valid_i is low, the register behind result_o does not load, so result_o keeps its value at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| mode_i | input | 1 | 0 = half-by-half, 1 = word-by-half |
| sel_a_i | input | 1 | Half select for op_a_i, 1 = top (half-by-half only) |
| sel_b_i | input | 1 | Half select for op_b_i, 1 = top |
| op_a_i | input | 32 | First operand |
| op_b_i | input | 32 | Second operand |
| valid_o | output | 1 | Result valid, one clock after valid_i |
| result_o | output | 32 | Registered result |

## Verification
Random operands rarely land on the points where the arithmetic is most fragile. One such point is the single product that reaches +2^30 from two most-negative halves. The other is a word-by-half product that is negative but smaller in magnitude than 2^16, where truncation must give -1 instead of 0. The stimulus therefore places these operand pairs directly. Each half-select combination is also given distinct top and bottom values, so a swapped select shows up as a different result. The effect of sel_a_i in word-by-half mode is checked by issuing the same request twice with sel_a_i flipped.

// File: rtl/smul_pkg.sv
package smul_pkg;
  typedef enum logic {
    MODE_HH = 1'b0,
    MODE_WH = 1'b1
  } smul_mode_e;
endpackage

// File: rtl/smul_half_sel.sv
module smul_half_sel #(
  parameter int DATA_W = 32,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic              top_i,
  output logic [HALF_W-1:0] half_o
);
  assign half_o = top_i ? word_i[DATA_W-1:HALF_W] : word_i[HALF_W-1:0];
endmodule

// File: rtl/smul_opnd_prep.sv
module smul_opnd_prep
  import smul_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int HALF_W = DATA_W / 2
) (
  input  smul_mode_e        mode_i,
  input  logic              sel_a_i,
  input  logic              sel_b_i,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  output logic [DATA_W-1:0] mul_a_o,
  output logic [HALF_W-1:0] mul_b_o
);
  logic [HALF_W-1:0] half_a;

  smul_half_sel #(.DATA_W(DATA_W)) u_sel_a (
    .word_i(op_a_i), .top_i(sel_a_i), .half_o(half_a)
  );
  smul_half_sel #(.DATA_W(DATA_W)) u_sel_b (
    .word_i(op_b_i), .top_i(sel_b_i), .half_o(mul_b_o)
  );

  // word mode passes operand A whole; half mode sign-extends the chosen half
  always_comb begin
    if (mode_i == MODE_WH) mul_a_o = op_a_i;
    else                   mul_a_o = {{(DATA_W-HALF_W){half_a[HALF_W-1]}}, half_a};
  end
endmodule

// File: rtl/smul_mult_core.sv
module smul_mult_core
  import smul_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int HALF_W = DATA_W / 2,
  localparam int PROD_W = DATA_W + HALF_W
) (
  input  smul_mode_e        mode_i,
  input  logic [DATA_W-1:0] mul_a_i,
  input  logic [HALF_W-1:0] mul_b_i,
  output logic [DATA_W-1:0] res_o
);
  logic signed [PROD_W-1:0] ext_a, ext_b, prod;

  assign ext_a = $signed({{HALF_W{mul_a_i[DATA_W-1]}}, mul_a_i});
  assign ext_b = $signed({{DATA_W{mul_b_i[HALF_W-1]}}, mul_b_i});
  assign prod  = ext_a * ext_b;

  // word mode keeps the upper bits, truncating the low half
  always_comb begin
    if (mode_i == MODE_WH) res_o = prod[PROD_W-1:HALF_W];
    else                   res_o = prod[DATA_W-1:0];
  end
endmodule

// File: rtl/hsmul_unit.sv
module hsmul_unit
  import smul_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              mode_i,
  input  logic              sel_a_i,
  input  logic              sel_b_i,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o
);
  smul_mode_e        mode;
  logic [DATA_W-1:0] mul_a, res_d, res_q;
  logic [HALF_W-1:0] mul_b;
  logic              vld_q;

  assign mode = smul_mode_e'(mode_i);

  smul_opnd_prep #(.DATA_W(DATA_W)) u_prep (
    .mode_i(mode), .sel_a_i(sel_a_i), .sel_b_i(sel_b_i),
    .op_a_i(op_a_i), .op_b_i(op_b_i), .mul_a_o(mul_a), .mul_b_o(mul_b)
  );

  smul_mult_core #(.DATA_W(DATA_W)) u_core (
    .mode_i(mode), .mul_a_i(mul_a), .mul_b_i(mul_b), .res_o(res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= valid_i;
      if (valid_i) res_q <= res_d;
    end
  end

  assign valid_o  = vld_q;
  assign result_o = res_q;
endmodule

// File: rtl/hsmul_unit_chk.sv
module hsmul_unit_chk #(
  parameter int DATA_W = 32,
  localparam int HALF_W = DATA_W / 2,
  localparam int PROD_W = DATA_W + HALF_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              mode_i,
  input logic              sel_a_i,
  input logic              sel_b_i,
  input logic [DATA_W-1:0] op_a_i,
  input logic [DATA_W-1:0] op_b_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o
);
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  function automatic logic [DATA_W-1:0] ref_hh(logic [DATA_W-1:0] a, logic [DATA_W-1:0] b,
                                               logic sa, logic sb);
    logic signed [DATA_W-1:0] xa, xb, p;
    logic [HALF_W-1:0] ha, hb;
    ha = sa ? a[DATA_W-1:HALF_W] : a[HALF_W-1:0];
    hb = sb ? b[DATA_W-1:HALF_W] : b[HALF_W-1:0];
    xa = $signed({{HALF_W{ha[HALF_W-1]}}, ha});
    xb = $signed({{HALF_W{hb[HALF_W-1]}}, hb});
    p  = xa * xb;
    return p;
  endfunction

  function automatic logic [DATA_W-1:0] ref_wh(logic [DATA_W-1:0] a, logic [DATA_W-1:0] b,
                                               logic sb);
    logic signed [PROD_W-1:0] xa, xb, p;
    logic [HALF_W-1:0] hb;
    hb = sb ? b[DATA_W-1:HALF_W] : b[HALF_W-1:0];
    xa = $signed({{HALF_W{a[DATA_W-1]}}, a});
    xb = $signed({{DATA_W{hb[HALF_W-1]}}, hb});
    p  = (xa * xb) >>> HALF_W;
    return p[DATA_W-1:0];
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_clear_R1: assert (!valid_o && result_o == '0);
    end
  end

  assert_valid_delay_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> valid_o == $past(valid_i));

  assert_hh_product_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(valid_i) && !$past(mode_i)) |->
      result_o == ref_hh($past(op_a_i), $past(op_b_i), $past(sel_a_i), $past(sel_b_i)));

  assert_wh_upper_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(valid_i) && $past(mode_i)) |->
      result_o == ref_wh($past(op_a_i), $past(op_b_i), $past(sel_b_i)));

  assert_hold_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !$past(valid_i)) |-> $stable(result_o));
endmodule

bind hsmul_unit hsmul_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .mode_i(mode_i),
  .sel_a_i(sel_a_i), .sel_b_i(sel_b_i), .op_a_i(op_a_i), .op_b_i(op_b_i),
  .valid_o(valid_o), .result_o(result_o)
);

// File: tb/sim_hsmul_unit.sv
`timescale 1ns/1ps
module sim_hsmul_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        mode_i = 1'b0;
  logic        sel_a_i = 1'b0;
  logic        sel_b_i = 1'b0;
  logic [31:0] op_a_i = '0;
  logic [31:0] op_b_i = '0;
  logic        valid_o;
  logic [31:0] result_o;

  int n_chk = 0;
  int n_fail = 0;
  logic done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  hsmul_unit u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .mode_i(mode_i),
    .sel_a_i(sel_a_i), .sel_b_i(sel_b_i), .op_a_i(op_a_i), .op_b_i(op_b_i),
    .valid_o(valid_o), .result_o(result_o)
  );

  function automatic logic [31:0] exp_res(logic m, logic sa, logic sb,
                                          logic [31:0] a, logic [31:0] b);
    longint ha, hb, wa, p;
    hb = longint'($signed(sb ? b[31:16] : b[15:0]));
    if (!m) begin
      ha = longint'($signed(sa ? a[31:16] : a[15:0]));
      p  = ha * hb;
      return p[31:0];
    end
    wa = longint'($signed(a));
    p  = wa * hb;
    return p[47:16];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive on the falling edge, sample 1 ns after the next rising edge
  task automatic issue(string req, logic m, logic sa, logic sb, logic [31:0] a, logic [31:0] b);
    @(negedge clk_i);
    valid_i = 1'b1; mode_i = m; sel_a_i = sa; sel_b_i = sb; op_a_i = a; op_b_i = b;
    @(posedge clk_i); #1;
    check({req, " valid"}, {31'b0, valid_o}, 32'd1);
    check(req, result_o, exp_res(m, sa, sb, a, b));
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r0, r1, held;
    void'($urandom(32'd4242));
    #12;
    check("R1 valid", {31'b0, valid_o}, 32'd0);
    check("R1 result", result_o, 32'd0);
    @(negedge clk_i); rst_ni = 1'b1;

    // R3: distinct halves, all four select pairs
    for (int s = 0; s < 4; s++)
      issue("R3", 1'b0, s[1], s[0], 32'h0003_FFF9, 32'hFFFE_0005);
    // R4: extreme halves
    issue("R4", 1'b0, 1'b0, 1'b1, 32'h0000_8000, 32'h8000_0000);
    issue("R4", 1'b0, 1'b1, 1'b0, 32'h7FFF_0000, 32'h0000_8000);
    issue("R4", 1'b0, 1'b0, 1'b0, 32'h1234_7FFF, 32'hABCD_7FFF);
    // R5: word mode
    issue("R5", 1'b1, 1'b0, 1'b1, 32'h8000_0000, 32'h8000_0000);
    issue("R5", 1'b1, 1'b0, 1'b0, 32'h7FFF_FFFF, 32'h0000_7FFF);
    // R6: truncation toward minus infinity
    issue("R6", 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001);
    issue("R6", 1'b1, 1'b0, 1'b1, 32'h0000_0001, 32'hFFFF_0000);
    issue("R6", 1'b1, 1'b0, 1'b0, 32'hFFFF_8000, 32'h0000_0003);

    // R7: sel_a flipped in word mode gives the same value
    issue("R7", 1'b1, 1'b0, 1'b1, 32'h1357_9BDF, 32'hC001_0002);
    r0 = result_o;
    issue("R7", 1'b1, 1'b1, 1'b1, 32'h1357_9BDF, 32'hC001_0002);
    r1 = result_o;
    check("R7 sel_a invariance", r1, r0);

    // R8: idle cycles with changing operands leave the result in place
    issue("R8", 1'b0, 1'b1, 1'b1, 32'h0042_0000, 32'h0011_0000);
    held = result_o;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i);
      valid_i = 1'b0; op_a_i = $urandom; op_b_i = $urandom; mode_i = k[0];
      @(posedge clk_i); #1;
      check("R8 hold", result_o, held);
      check("R2 idle valid", {31'b0, valid_o}, 32'd0);
    end

    // R2/R4/R5: back-to-back random requests
    @(negedge clk_i);
    for (int k = 0; k < 300; k++) begin
      logic m, sa, sb;
      logic [31:0] a, b;
      m = 1'($urandom); sa = 1'($urandom); sb = 1'($urandom);
      a = $urandom; b = $urandom;
      valid_i = 1'b1; mode_i = m; sel_a_i = sa; sel_b_i = sb; op_a_i = a; op_b_i = b;
      @(posedge clk_i); #1;
      check("R2 valid", {31'b0, valid_o}, 32'd1);
      check(m ? "R5 random" : "R4 random", result_o, exp_res(m, sa, sb, a, b));
      @(negedge clk_i);
    end
    valid_i = 1'b0;
    @(posedge clk_i); #1;
    check("R2 drop", {31'b0, valid_o}, 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule